// File: doc/BRIEF.md
# Local Bus Chip-Select Bank Decoder

This block maps each transaction on a local memory bus onto one of eight configurable banks. Every bank is described by two 32-bit words. The base word holds a base address and the bank's attributes: valid, data port width, the kind of memory machine that serves the bank, the ECC mode and a write-protect flag. The option word holds an address mask. A request is an address and a write flag qualified by a strobe. One clock later the block presents a one-hot chip select and the winning bank's attributes. It pulses an error if the request either hits nothing or tries to write a protected bank.

Configuration uses a plain write port (bank index, base/option selector, data) and a combinational read port. Bits that carry no meaning are forced to zero on write. The request side has no back-pressure. Each strobe is decoded, and the one-cycle registered result can be taken in every cycle, so requests may arrive back to back.

Top module: `lbus_bank_decoder`

## Requirements
- R1: Only base-word bits 31:15, 12:5 and 0 and option-word bits 31:15 are stored. All other bits read back as zero whatever value was written. Both words reset to zero.
- R2: A bank matches a request address when `(addr[31:15] & option[31:15]) == (base[31:15] & option[31:15])`. Address bits 14:0 never affect the decode.
- R3: A bank whose base bit 0 (valid) is clear never matches.
- R4: When several valid banks match, the lowest-numbered one is selected.
- R5: The outputs reflect the request sampled at a clock edge and are registered at that same edge. `cs_o` is one-hot with the bit of the selected bank, or all zeros.
- R6: `psize_o` carries base bits 12:11 of the selected bank (01 = 8-bit, 10 = 16-bit, 11 = 32-bit).
- R7: `mach_o` carries base bits 7:5 of the selected bank (000 general-purpose, 001 NAND flash, 011 SDRAM, 100/101/110 programmable machines A/B/C).
- R8: `ecc_o` carries base bits 10:9 of the selected bank (00 off, 01 check, 10 check and generate).
- R9: A write request whose selected bank has base bit 8 set asserts no chip select. It raises `hit_o` and a one-cycle `wp_err_o`, and it still reports that bank's attributes. A read of such a bank is decoded normally.
- R10: A request that matches no valid bank gives `cs_o` = 0, `hit_o` = 0 and zero attributes, and it pulses `nohit_err_o` for one cycle.
- R11: In a cycle following an edge with no request, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_opt | input | 1 | Selects the word to write: 0 base, 1 option |
| cfg_idx | input | 3 | Bank index to write |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rd_opt | input | 1 | Selects the word to read: 0 base, 1 option |
| cfg_rd_idx | input | 3 | Bank index to read |
| cfg_rdata | output | 32 | Combinational read data |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Request address |
| req_write | input | 1 | Request is a write |
| cs_o | output | 8 | One-hot chip select |
| hit_o | output | 1 | A valid bank was selected |
| psize_o | output | 2 | Port width of selected bank |
| mach_o | output | 3 | Memory machine of selected bank |
| ecc_o | output | 2 | ECC mode of selected bank |
| wp_err_o | output | 1 | Write-protect violation pulse |
| nohit_err_o | output | 1 | No-bank-matched pulse |

## Verification
The hardest case to reach is overlap resolution. It needs two or more valid banks whose masked windows cover the same address while also differing in valid state and protection. A wide low bank is therefore placed over a narrow higher bank, and one bank is disabled on a window that another bank still covers. Requests are then aimed at the overlap, both before and after the low bank is invalidated. Random addresses biased towards the programmed windows, mixed with idle gaps and back-to-back strobes, are checked every cycle against a behavioural model.

// File: rtl/lbd_pkg.sv
package lbd_pkg;
  localparam int unsigned WORD_W = 32;

  // Storable bit masks for the two per-bank words
  localparam logic [WORD_W-1:0] BASE_KEEP  = 32'hFFFF_9FE1;
  localparam logic [WORD_W-1:0] OPT_KEEP   = 32'hFFFF_8000;
  localparam logic [WORD_W-1:0] MATCH_BITS = 32'hFFFF_8000;

  typedef struct packed {
    logic [1:0] psize;
    logic [1:0] ecc;
    logic       wprot;
    logic [2:0] mach;
    logic       valid;
  } bank_attr_t;

  function automatic bank_attr_t attr_of(input logic [WORD_W-1:0] w);
    bank_attr_t a;
    a.psize = w[12:11];
    a.ecc   = w[10:9];
    a.wprot = w[8];
    a.mach  = w[7:5];
    a.valid = w[0];
    return a;
  endfunction
endpackage

// File: rtl/lbd_bank_regs.sv
module lbd_bank_regs
  import lbd_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  localparam int unsigned IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              sel_opt,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] base_q [NUM_BANKS],
  output logic [WORD_W-1:0] opt_q  [NUM_BANKS]
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit_idx;
    assign hit_idx = we && (idx == IDX_W'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[b] <= '0;
        opt_q[b]  <= '0;
      end else if (hit_idx) begin
        if (sel_opt) opt_q[b]  <= wdata & OPT_KEEP;
        else         base_q[b] <= wdata & BASE_KEEP;
      end
    end
  end
endmodule

// File: rtl/lbd_match.sv
module lbd_match
  import lbd_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8
) (
  input  logic [WORD_W-1:0]    addr,
  input  logic [WORD_W-1:0]    base_q [NUM_BANKS],
  input  logic [WORD_W-1:0]    opt_q  [NUM_BANKS],
  output logic [NUM_BANKS-1:0] match
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cmp
    logic [WORD_W-1:0] diff;
    assign diff     = (addr ^ base_q[b]) & opt_q[b] & MATCH_BITS;
    assign match[b] = base_q[b][0] && (diff == '0);
  end
endmodule

// File: rtl/lbd_prio.sv
module lbd_prio #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  always_comb begin
    logic taken;
    taken = 1'b0;
    grant = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !taken) begin
        grant[i] = 1'b1;
        taken    = 1'b1;
      end
    end
    any = taken;
  end
endmodule

// File: rtl/lbus_bank_decoder.sv
module lbus_bank_decoder
  import lbd_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  localparam int unsigned IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic                 cfg_opt,
  input  logic [IDX_W-1:0]     cfg_idx,
  input  logic [31:0]          cfg_wdata,
  input  logic                 cfg_rd_opt,
  input  logic [IDX_W-1:0]     cfg_rd_idx,
  output logic [31:0]          cfg_rdata,
  input  logic                 req_valid,
  input  logic [31:0]          req_addr,
  input  logic                 req_write,
  output logic [NUM_BANKS-1:0] cs_o,
  output logic                 hit_o,
  output logic [1:0]           psize_o,
  output logic [2:0]           mach_o,
  output logic [1:0]           ecc_o,
  output logic                 wp_err_o,
  output logic                 nohit_err_o
);
  logic [WORD_W-1:0]    base_q [NUM_BANKS];
  logic [WORD_W-1:0]    opt_q  [NUM_BANKS];
  logic [NUM_BANKS-1:0] match, grant;
  logic                 any;
  bank_attr_t           sel_attr;

  lbd_bank_regs #(.NUM_BANKS(NUM_BANKS)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel_opt(cfg_opt),
    .idx(cfg_idx), .wdata(cfg_wdata), .base_q(base_q), .opt_q(opt_q)
  );

  lbd_match #(.NUM_BANKS(NUM_BANKS)) u_match (
    .addr(req_addr), .base_q(base_q), .opt_q(opt_q), .match(match)
  );

  lbd_prio #(.N(NUM_BANKS)) u_prio (
    .req(match), .grant(grant), .any(any)
  );

  // Read-back mux; indices past the last bank read as zero
  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NUM_BANKS; i++)
      if (cfg_rd_idx == IDX_W'(i))
        cfg_rdata = cfg_rd_opt ? opt_q[i] : base_q[i];
  end

  // AND-OR select of the granted bank's attributes
  always_comb begin
    sel_attr = '0;
    for (int i = 0; i < NUM_BANKS; i++)
      if (grant[i]) sel_attr = sel_attr | attr_of(base_q[i]);
  end

  logic blocked;
  assign blocked = any && req_write && sel_attr.wprot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_o        <= '0;
      hit_o       <= 1'b0;
      psize_o     <= '0;
      mach_o      <= '0;
      ecc_o       <= '0;
      wp_err_o    <= 1'b0;
      nohit_err_o <= 1'b0;
    end else if (req_valid) begin
      cs_o        <= blocked ? '0 : grant;
      hit_o       <= any;
      psize_o     <= sel_attr.psize;
      mach_o      <= sel_attr.mach;
      ecc_o       <= sel_attr.ecc;
      wp_err_o    <= blocked;
      nohit_err_o <= !any;
    end else begin
      cs_o        <= '0;
      hit_o       <= 1'b0;
      psize_o     <= '0;
      mach_o      <= '0;
      ecc_o       <= '0;
      wp_err_o    <= 1'b0;
      nohit_err_o <= 1'b0;
    end
  end
endmodule

// File: rtl/lbd_checker.sv
module lbd_checker #(
  parameter int unsigned NUM_BANKS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_write,
  input logic [NUM_BANKS-1:0] cs_o,
  input logic                 hit_o,
  input logic                 wp_err_o,
  input logic                 nohit_err_o
);
  p_cs_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_o));

  p_wp_blocks_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wp_err_o |-> (cs_o == '0) && hit_o);

  p_wp_needs_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> !wp_err_o);

  p_nohit_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    nohit_err_o |-> (cs_o == '0) && !hit_o && !wp_err_o);

  p_hit_or_miss_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (hit_o != nohit_err_o));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (cs_o == '0) && !hit_o && !wp_err_o && !nohit_err_o);

  p_cs_implies_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_o != '0) |-> hit_o);
endmodule

bind lbus_bank_decoder lbd_checker #(.NUM_BANKS(NUM_BANKS)) u_lbd_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .cs_o(cs_o), .hit_o(hit_o), .wp_err_o(wp_err_o), .nohit_err_o(nohit_err_o)
);

// File: tb/lbus_bank_decoder_tb.sv
module lbus_bank_decoder_tb_top;
  localparam int CLK_P = 10;
  localparam int NB = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_opt = 1'b0, cfg_rd_opt = 1'b0;
  logic [2:0]  cfg_idx = '0, cfg_rd_idx = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [7:0]  cs_o;
  logic        hit_o, wp_err_o, nohit_err_o;
  logic [1:0]  psize_o, ecc_o;
  logic [2:0]  mach_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string phase = "reset";

  always #(CLK_P/2) clk = ~clk;

  lbus_bank_decoder #(.NUM_BANKS(NB)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_opt(cfg_opt),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rd_opt(cfg_rd_opt),
    .cfg_rd_idx(cfg_rd_idx), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .req_write(req_write), .cs_o(cs_o), .hit_o(hit_o),
    .psize_o(psize_o), .mach_o(mach_o), .ecc_o(ecc_o), .wp_err_o(wp_err_o),
    .nohit_err_o(nohit_err_o)
  );

  // ---------------- behavioural model ----------------
  logic [31:0] mbase [NB];
  logic [31:0] mopt  [NB];
  logic [7:0]  e_cs;
  logic        e_hit, e_wp, e_nohit;
  logic [1:0]  e_ps, e_ecc;
  logic [2:0]  e_mach;

  initial for (int i = 0; i < NB; i++) begin mbase[i] = 0; mopt[i] = 0; end

  always @(posedge clk) begin
    int w;
    e_cs = 0; e_hit = 0; e_wp = 0; e_nohit = 0; e_ps = 0; e_ecc = 0; e_mach = 0;
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) begin mbase[i] = 0; mopt[i] = 0; end
    end else begin
      if (req_valid) begin
        w = -1;
        for (int i = NB - 1; i >= 0; i--)        // R2 R3 R4: last assignment = lowest index
          if (mbase[i][0] && (((req_addr >> 15) & (mopt[i] >> 15)) ==
                              ((mbase[i] >> 15) & (mopt[i] >> 15))))
            w = i;
        if (w < 0) e_nohit = 1;
        else begin
          e_hit  = 1;
          e_ps   = mbase[w][12:11];
          e_ecc  = mbase[w][10:9];
          e_mach = mbase[w][7:5];
          if (req_write && mbase[w][8]) e_wp = 1;
          else e_cs = 8'(1 << w);
        end
      end
      if (cfg_we) begin
        if (cfg_opt) mopt[cfg_idx] = cfg_wdata & 32'hFFFF_8000;
        else         mbase[cfg_idx] = cfg_wdata & 32'hFFFF_9FE1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s [%s] t=%0t actual=%h expected=%h", req, phase, $time, act, exp);
    end
  endtask

  // Compare every output on every clock, away from the active edge
  always @(negedge clk) if (!done) begin
    chk("R5 cs", 32'(cs_o), 32'(e_cs));
    chk("R2 hit", 32'(hit_o), 32'(e_hit));
    chk("R6 psize", 32'(psize_o), 32'(e_ps));
    chk("R7 mach", 32'(mach_o), 32'(e_mach));
    chk("R8 ecc", 32'(ecc_o), 32'(e_ecc));
    chk("R9 wp_err", 32'(wp_err_o), 32'(e_wp));
    chk("R10 nohit", 32'(nohit_err_o), 32'(e_nohit));
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(); @(negedge clk); endtask

  task automatic wr_cfg(input int idx, input bit opt, input logic [31:0] d);
    cfg_we = 1; cfg_idx = 3'(idx); cfg_opt = opt; cfg_wdata = d;
    tick();
    cfg_we = 0;
  endtask

  task automatic req(input logic [31:0] a, input bit w);
    req_valid = 1; req_addr = a; req_write = w;
    tick();
    req_valid = 0;
  endtask

  task automatic rd_chk(input string tag, input int idx, input bit opt, input logic [31:0] exp);
    cfg_rd_idx = 3'(idx); cfg_rd_opt = opt;
    #1;
    chk(tag, cfg_rdata, exp);
  endtask

  function automatic logic [31:0] mk(input logic [31:0] a, input int ps, input int ecc,
                                     input bit wp, input int mach, input bit v);
    return (a & 32'hFFFF_8000) | 32'(ps << 11) | 32'(ecc << 9) | 32'(wp << 8)
           | 32'(mach << 5) | 32'(v);
  endfunction

  // ---------------- scenario ----------------
  initial begin
    tick(); tick();
    phase = "reset R1";
    for (int i = 0; i < NB; i++) begin
      rd_chk("R1 reset base", i, 0, 0);
      rd_chk("R1 reset opt", i, 1, 0);
    end
    rst_n = 1;
    tick();

    phase = "empty R10";
    req(32'h1234_5678, 0);
    req(32'h0000_0000, 1);
    tick();

    phase = "masks R1";
    wr_cfg(7, 0, 32'hFFFF_FFFF);
    wr_cfg(7, 1, 32'hFFFF_FFFF);
    rd_chk("R1 base mask", 7, 0, 32'hFFFF_9FE1);
    rd_chk("R1 opt mask", 7, 1, 32'hFFFF_8000);
    wr_cfg(7, 0, 32'h0000_601E);
    rd_chk("R1 reserved only", 7, 0, 32'h0000_0000);

    phase = "program";
    wr_cfg(0, 0, mk(32'h1000_0000, 3, 0, 0, 0, 1)); wr_cfg(0, 1, 32'hF000_0000);
    wr_cfg(1, 0, mk(32'h1000_8000, 2, 2, 0, 3, 1)); wr_cfg(1, 1, 32'hFFFF_8000);
    wr_cfg(2, 0, mk(32'h2000_0000, 1, 1, 1, 1, 1)); wr_cfg(2, 1, 32'hFFFF_0000);
    wr_cfg(3, 0, mk(32'h3000_0000, 3, 0, 0, 4, 0)); wr_cfg(3, 1, 32'hFF00_0000);
    wr_cfg(4, 0, mk(32'h4000_0000, 2, 2, 0, 3, 1)); wr_cfg(4, 1, 32'hFFFF_8000);
    wr_cfg(5, 0, mk(32'h5000_0000, 1, 0, 0, 6, 1)); wr_cfg(5, 1, 32'hFFC0_0000);
    wr_cfg(6, 0, mk(32'h7000_0000, 3, 1, 1, 5, 1)); wr_cfg(6, 1, 32'hFFFF_8000);
    rd_chk("R1 base2", 2, 0, mk(32'h2000_0000, 1, 1, 1, 1, 1));

    phase = "overlap R4";
    req(32'h1000_8004, 0);
    req(32'h1000_8004, 1);
    phase = "window R2";
    req(32'h4000_7FFF, 0);
    req(32'h4000_8000, 0);
    req(32'h5030_0000, 1);
    phase = "invalid R3";
    req(32'h3000_0000, 0);
    phase = "protect R9";
    req(32'h2000_1234, 1);
    req(32'h2000_1234, 0);
    req(32'h7000_0010, 1);
    tick();
    phase = "idle R11";
    tick(); tick();

    phase = "disable low R4";
    wr_cfg(0, 0, mk(32'h1000_0000, 3, 0, 0, 0, 0));
    req(32'h1000_8004, 0);
    req(32'h1000_0000, 0);
    phase = "enable R3";
    wr_cfg(3, 0, mk(32'h3000_0000, 3, 0, 0, 4, 1));
    req(32'h30AB_CDEF, 1);
    wr_cfg(0, 0, mk(32'h1000_0000, 3, 0, 0, 0, 1));

    phase = "random R2 R4 R9 R11";
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] a;
      int r;
      r = int'($urandom_range(0, 7));
      a = ($urandom() & 32'h0FFF_FFFF) | (32'(r) << 28);
      if ($urandom_range(0, 3) == 0) a = a & 32'hF000_FFFF;
      req_valid = ($urandom_range(0, 4) != 0);
      req_addr = a; req_write = $urandom_range(0, 1) == 1;
      if ($urandom_range(0, 50) == 0) begin
        cfg_we = 1; cfg_opt = 0; cfg_idx = 3'($urandom_range(0, 7));
        cfg_wdata = mk(32'(r) << 28, int'($urandom_range(1, 3)), int'($urandom_range(0, 2)),
                       $urandom_range(0, 1) == 1, int'($urandom_range(0, 6)), 1);
      end
      tick();
      cfg_we = 0;
    end
    req_valid = 0;
    tick(); tick();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule